// File: doc/BRIEF.md
# Configuration Access Translator

This block sits in front of a root-complex port and converts one configuration-space request at a time into a plain memory-style access. A request names a bus, a device, a function, a register offset and a direction. Requests for bus 0 go straight to the port's own register block. Every other bus goes through a 1 MB outbound window at the top of a 16 MB region. Before the access is issued, the window's translation target and its transaction type are loaded for that request.

Some device numbers cannot exist, and the block refuses them without touching the bus. Such a request completes at once with all ones and an error. A downstream access that aborts also completes with all ones and an error, for example a bridge with nothing behind it. No request can hang the requester as long as the downstream side ends each access with either a done or an abort. Requests use a valid/ready handshake. Responses arrive as a one-cycle pulse that carries the data and the error bit.

Top module: `cfg_xlate`

## Requirements
- R1: `reqReady` is high only when no request is in flight. After a request is accepted, no further request is accepted until its response has been given. `rspValid` is a single-cycle pulse per request.
- R2: While an access is issued, `winType` is 4 (Type 0 configuration) for buses 0 and 1 and 5 (Type 1 configuration) for any higher bus.
- R3: A valid bus-0 request is issued at `busAddr` = LOCAL_BASE (default 0x01FFC000) plus the aligned offset. `winTarget` keeps the value it had before the request.
- R4: A valid request on any bus other than 0 is issued at `busAddr` = region base + 15 MB (default 0x01F00000) plus the aligned offset. `winTarget` holds the bus in bits 31:24, the device in bits 23:19, the function in bits 18:16 and zeros elsewhere.
- R5: The register offset has its two low bits cleared before it is added, so `busAddr[1:0]` is always 0.
- R6: On bus 0 only devices 0 and 1 are valid, and on bus 1 only device 0 is valid. A request to any other device on those buses issues no bus access and responds with `rspData` = 0xFFFFFFFF and `rspErr` = 1.
- R7: A rejected write is discarded: `busReq` stays low for the whole request.
- R8: When the downstream side signals `busAbort`, the response is `rspData` = 0xFFFFFFFF with `rspErr` = 1, for reads and for writes. An abort wins over a done raised in the same cycle.
- R9: A completed read returns `busRdata` with `rspErr` = 0. A completed write returns zero data with `rspErr` = 0. `busWrite` and `busWdata` follow the request.
- R10: `winEnable` is 0 after reset. It goes to 1 once the first valid request has programmed the window, and it stays 1 from then on. Rejected requests do not set it.
- R11: Once raised, `busReq` stays high with a stable address until `busDone` or `busAbort` is seen.
- R12: After reset `reqReady` = 1, `rspValid` = 0 and `busReq` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Translator can take a request |
| reqBus | input | 8 | Bus number |
| reqDev | input | 5 | Device number |
| reqFunc | input | 3 | Function number |
| reqOffset | input | 12 | Register byte offset |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqWdata | input | 32 | Write data |
| rspValid | output | 1 | Response pulse |
| rspData | output | 32 | Read data, all ones on error |
| rspErr | output | 1 | Rejected or aborted |
| busReq | output | 1 | Downstream access in progress |
| busAddr | output | 32 | Physical access address |
| busWrite | output | 1 | Downstream direction |
| busWdata | output | 32 | Downstream write data |
| busDone | input | 1 | Downstream access completed |
| busAbort | input | 1 | Downstream access aborted |
| busRdata | input | 32 | Downstream read data, taken with busDone |
| winTarget | output | 32 | Outbound window translation target |
| winType | output | 5 | Outbound window transaction type |
| winEnable | output | 1 | Outbound window enabled |

## Verification
The assertions assume that the downstream side raises `busDone` or `busAbort` only while `busReq` is high and holds it for a single cycle. They also assume that requests are presented only through the handshake. The bench's downstream model answers each issued access after a random delay of 0 to 4 cycles and drops its done or abort strobe on the next cycle. Requests are driven one at a time and `reqValid` is released right after acceptance, so the stimulus never departs from these assumptions. The random requests favour buses 0 to 2 and low device numbers, so that the reject boundaries are hit often.

// File: rtl/cfg_xlate_pkg.sv
package cfg_xlate_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_ISSUE  = 2'd2,
    ST_RESP   = 2'd3
  } xlState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic capReq;     // latch incoming request
    logic progWin;    // load window type/target
    logic takeBus;    // latch downstream outcome
    logic takeReject; // load rejected-request response
  } xlStrobe_t;

  localparam int TYPE_W = 5;
  localparam logic [TYPE_W-1:0] CFG_TYPE_LOCAL = 5'd4;
  localparam logic [TYPE_W-1:0] CFG_TYPE_FWD   = 5'd5;

endpackage

// File: rtl/cfg_xlate_ctrl.sv
module cfg_xlate_ctrl
  import cfg_xlate_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      devOk,
  input  logic      busDone,
  input  logic      busAbort,
  output logic      reqReady,
  output logic      busReq,
  output logic      rspValid,
  output xlStrobe_t strobe
);

  xlState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.capReq = 1'b1;
          stateNext     = ST_DECODE;
        end
      end
      ST_DECODE: begin
        if (devOk) begin
          strobe.progWin = 1'b1;
          stateNext      = ST_ISSUE;
        end else begin
          strobe.takeReject = 1'b1;
          stateNext         = ST_RESP;
        end
      end
      ST_ISSUE: begin
        if (busDone || busAbort) begin
          strobe.takeBus = 1'b1;
          stateNext      = ST_RESP;
        end
      end
      ST_RESP: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign reqReady = (state == ST_IDLE);
  assign busReq   = (state == ST_ISSUE);
  assign rspValid = (state == ST_RESP);

endmodule

// File: rtl/cfg_xlate_datapath.sv
module cfg_xlate_datapath
  import cfg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FUNC_W = 3,
  parameter int OFF_W  = 12,
  parameter logic [ADDR_W-1:0] LOCAL_BASE  = 32'h01FF_C000,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h0100_0000,
  parameter logic [ADDR_W-1:0] REGION_SIZE = 32'h0100_0000,
  parameter logic [ADDR_W-1:0] WINDOW_SIZE = 32'h0010_0000
)(
  input  logic              clk,
  input  logic              rstN,
  input  xlStrobe_t         strobe,
  input  logic [BUS_W-1:0]  reqBus,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [FUNC_W-1:0] reqFunc,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              busAbort,
  input  logic [DATA_W-1:0] busRdata,
  output logic              devOk,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWrite,
  output logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr,
  output logic [ADDR_W-1:0] winTarget,
  output logic [TYPE_W-1:0] winType,
  output logic              winEnable
);

  localparam logic [ADDR_W-1:0] WIN_BASE = REGION_BASE + REGION_SIZE - WINDOW_SIZE;
  localparam int BUS_LSB  = ADDR_W - BUS_W;
  localparam int DEV_LSB  = BUS_LSB - DEV_W;
  localparam int FUNC_LSB = DEV_LSB - FUNC_W;
  localparam logic [DATA_W-1:0] ALL_ONES = '1;

  logic [BUS_W-1:0]  rBus;
  logic [DEV_W-1:0]  rDev;
  logic [FUNC_W-1:0] rFunc;
  logic [OFF_W-1:0]  rOff;
  logic              rWrite;
  logic [DATA_W-1:0] rWdata;

  logic              isLocalBus;
  logic              isFirstBus;
  logic [ADDR_W-1:0] alignedOff;
  logic [ADDR_W-1:0] tgtNext;

  // request capture
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rBus   <= '0;
      rDev   <= '0;
      rFunc  <= '0;
      rOff   <= '0;
      rWrite <= 1'b0;
      rWdata <= '0;
    end else if (strobe.capReq) begin
      rBus   <= reqBus;
      rDev   <= reqDev;
      rFunc  <= reqFunc;
      rOff   <= reqOffset;
      rWrite <= reqWrite;
      rWdata <= reqWdata;
    end
  end

  assign isLocalBus = (rBus == '0);
  assign isFirstBus = (rBus == BUS_W'(1));

  // device existence rule on the two innermost buses
  always_comb begin
    if (isLocalBus)      devOk = (rDev <= DEV_W'(1));
    else if (isFirstBus) devOk = (rDev == '0);
    else                 devOk = 1'b1;
  end

  assign alignedOff = {{(ADDR_W-OFF_W){1'b0}}, rOff[OFF_W-1:2], 2'b00};
  assign busAddr    = (isLocalBus ? LOCAL_BASE : WIN_BASE) + alignedOff;
  assign busWrite   = rWrite;
  assign busWdata   = rWdata;

  always_comb begin
    tgtNext = '0;
    tgtNext[BUS_LSB  +: BUS_W]  = rBus;
    tgtNext[DEV_LSB  +: DEV_W]  = rDev;
    tgtNext[FUNC_LSB +: FUNC_W] = rFunc;
  end

  // outbound window programming
  always_ff @(posedge clk) begin
    if (!rstN) begin
      winTarget <= '0;
      winType   <= CFG_TYPE_LOCAL;
      winEnable <= 1'b0;
    end else if (strobe.progWin) begin
      winType   <= (rBus <= BUS_W'(1)) ? CFG_TYPE_LOCAL : CFG_TYPE_FWD;
      winEnable <= 1'b1;
      if (!isLocalBus) winTarget <= tgtNext;
    end
  end

  // response registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspData <= '0;
      rspErr  <= 1'b0;
    end else if (strobe.takeReject) begin
      rspData <= ALL_ONES;
      rspErr  <= 1'b1;
    end else if (strobe.takeBus) begin
      if (busAbort) begin
        rspData <= ALL_ONES;
        rspErr  <= 1'b1;
      end else begin
        rspData <= rWrite ? '0 : busRdata;
        rspErr  <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cfg_xlate.sv
module cfg_xlate
  import cfg_xlate_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int BUS_W  = 8,
  parameter int DEV_W  = 5,
  parameter int FUNC_W = 3,
  parameter int OFF_W  = 12,
  parameter logic [ADDR_W-1:0] LOCAL_BASE  = 32'h01FF_C000,
  parameter logic [ADDR_W-1:0] REGION_BASE = 32'h0100_0000,
  parameter logic [ADDR_W-1:0] REGION_SIZE = 32'h0100_0000,
  parameter logic [ADDR_W-1:0] WINDOW_SIZE = 32'h0010_0000
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [BUS_W-1:0]  reqBus,
  input  logic [DEV_W-1:0]  reqDev,
  input  logic [FUNC_W-1:0] reqFunc,
  input  logic [OFF_W-1:0]  reqOffset,
  input  logic              reqWrite,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              rspErr,
  output logic              busReq,
  output logic [ADDR_W-1:0] busAddr,
  output logic              busWrite,
  output logic [DATA_W-1:0] busWdata,
  input  logic              busDone,
  input  logic              busAbort,
  input  logic [DATA_W-1:0] busRdata,
  output logic [ADDR_W-1:0] winTarget,
  output logic [TYPE_W-1:0] winType,
  output logic              winEnable
);

  xlStrobe_t strobe;
  logic      devOk;

  cfg_xlate_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .devOk    (devOk),
    .busDone  (busDone),
    .busAbort (busAbort),
    .reqReady (reqReady),
    .busReq   (busReq),
    .rspValid (rspValid),
    .strobe   (strobe)
  );

  cfg_xlate_datapath #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BUS_W(BUS_W), .DEV_W(DEV_W),
    .FUNC_W(FUNC_W), .OFF_W(OFF_W), .LOCAL_BASE(LOCAL_BASE),
    .REGION_BASE(REGION_BASE), .REGION_SIZE(REGION_SIZE),
    .WINDOW_SIZE(WINDOW_SIZE)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqBus    (reqBus),
    .reqDev    (reqDev),
    .reqFunc   (reqFunc),
    .reqOffset (reqOffset),
    .reqWrite  (reqWrite),
    .reqWdata  (reqWdata),
    .busAbort  (busAbort),
    .busRdata  (busRdata),
    .devOk     (devOk),
    .busAddr   (busAddr),
    .busWrite  (busWrite),
    .busWdata  (busWdata),
    .rspData   (rspData),
    .rspErr    (rspErr),
    .winTarget (winTarget),
    .winType   (winType),
    .winEnable (winEnable)
  );

endmodule

// File: rtl/cfg_xlate_chk.sv
module cfg_xlate_chk #(
  parameter int ADDR_W = 32,
  parameter int TYPE_W = 5
)(
  input logic              clk,
  input logic              rstN,
  input logic              reqReady,
  input logic              rspValid,
  input logic              busReq,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busDone,
  input logic              busAbort,
  input logic [TYPE_W-1:0] winType,
  input logic              winEnable
);

  p_rsp_pulse_r1: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  p_busy_not_ready_r1: assert property (@(posedge clk) disable iff (!rstN)
    (busReq || rspValid) |-> !reqReady);

  p_type_code_r2: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (winType == 5'd4 || winType == 5'd5));

  p_aligned_r5: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> (busAddr[1:0] == 2'b00));

  p_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    (busReq && !busDone && !busAbort) |=> (busReq && $stable(busAddr)));

  p_enable_on_issue_r10: assert property (@(posedge clk) disable iff (!rstN)
    busReq |-> winEnable);

  p_enable_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    winEnable |=> winEnable);

endmodule

bind cfg_xlate cfg_xlate_chk #(.ADDR_W(ADDR_W), .TYPE_W(5)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqReady  (reqReady),
  .rspValid  (rspValid),
  .busReq    (busReq),
  .busAddr   (busAddr),
  .busDone   (busDone),
  .busAbort  (busAbort),
  .winType   (winType),
  .winEnable (winEnable)
);

// File: tb/cfg_xlate_tb.sv
module cfg_xlate_tb;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [7:0]  reqBus = '0;
  logic [4:0]  reqDev = '0;
  logic [2:0]  reqFunc = '0;
  logic [11:0] reqOffset = '0;
  logic        reqWrite = 1'b0;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        rspErr;
  logic        busReq;
  logic [31:0] busAddr;
  logic        busWrite;
  logic [31:0] busWdata;
  logic        busDone = 1'b0;
  logic        busAbort = 1'b0;
  logic [31:0] busRdata = '0;
  logic [31:0] winTarget;
  logic [4:0]  winType;
  logic        winEnable;

  int errors = 0;
  int checks = 0;
  logic [31:0] modelTarget = '0;
  logic        modelEnable = 1'b0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  cfg_xlate u_dut (.*);

  function automatic bit expValid(input logic [7:0] b, input logic [4:0] d);
    if (b == 8'd0) return d <= 5'd1;
    if (b == 8'd1) return d == 5'd0;
    return 1'b1;
  endfunction

  function automatic logic [31:0] expAddr(input logic [7:0] b, input logic [11:0] o);
    logic [31:0] base = (b == 8'd0) ? 32'h01FF_C000 : 32'h01F0_0000;
    return base + {20'd0, o[11:2], 2'b00};
  endfunction

  function automatic logic [31:0] expTarget(input logic [7:0] b, input logic [4:0] d,
                                            input logic [2:0] f);
    return {b, d, f, 16'h0000};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one request end to end; kind 0 = done, 1 = abort, 2 = done+abort together
  task automatic runReq(input logic [7:0] b, input logic [4:0] d, input logic [2:0] f,
                        input logic [11:0] o, input bit wr, input logic [31:0] wd,
                        input int kind, input int delay, input logic [31:0] rd);
    bit ok = expValid(b, d);
    bit sawBus = 1'b0;
    bit gotRsp = 1'b0;
    int waited = 0;
    logic [31:0] expData;
    bit expErr;
    @(negedge clk);
    reqValid = 1'b1; reqBus = b; reqDev = d; reqFunc = f;
    reqOffset = o; reqWrite = wr; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    check(!reqReady, "R1 ready low after accept", {31'd0, reqReady}, 32'd0);
    for (int i = 0; i < 30 && !gotRsp; i++) begin
      if (i > 0) @(negedge clk);
      busDone = 1'b0; busAbort = 1'b0;
      if (rspValid) begin
        gotRsp = 1'b1;
        if (!ok) begin
          expData = 32'hFFFF_FFFF; expErr = 1'b1;
        end else if (kind != 0) begin
          expData = 32'hFFFF_FFFF; expErr = 1'b1;
        end else begin
          expData = wr ? 32'd0 : rd; expErr = 1'b0;
        end
        if (!ok)            check(rspData == expData, "R6 reject data", rspData, expData);
        else if (kind != 0) check(rspData == expData, "R8 abort data", rspData, expData);
        else                check(rspData == expData, "R9 completion data", rspData, expData);
        check(rspErr == expErr, ok ? (kind != 0 ? "R8 abort err" : "R9 err") : "R6 reject err",
              {31'd0, rspErr}, {31'd0, expErr});
        check(!reqReady, "R1 ready low during response", {31'd0, reqReady}, 32'd0);
      end else if (busReq) begin
        if (!sawBus) begin
          sawBus = 1'b1;
          check(busAddr == expAddr(b, o), (b == 0) ? "R3 local address" : "R4 window address",
                busAddr, expAddr(b, o));
          check(busAddr[1:0] == 2'b00, "R5 aligned", busAddr, expAddr(b, o));
          check(winType == ((b <= 1) ? 5'd4 : 5'd5), "R2 type code",
                {27'd0, winType}, (b <= 1) ? 32'd4 : 32'd5);
          if (b != 0) modelTarget = expTarget(b, d, f);
          check(winTarget == modelTarget, (b == 0) ? "R3 target kept" : "R4 target fields",
                winTarget, modelTarget);
          check(busWrite == wr && busWdata == wd, "R9 write fields", busWdata, wd);
          modelEnable = 1'b1;
          check(winEnable == 1'b1, "R10 enable set", {31'd0, winEnable}, 32'd1);
        end else begin
          check(busAddr == expAddr(b, o), "R11 address held", busAddr, expAddr(b, o));
        end
        if (waited == delay) begin
          busDone  = (kind != 1);
          busAbort = (kind != 0);
          busRdata = rd;
        end
        waited++;
      end
    end
    check(gotRsp, "R1 response seen", {31'd0, gotRsp}, 32'd1);
    if (!ok) check(!sawBus, wr ? "R7 rejected write discarded" : "R6 no bus access",
                   {31'd0, sawBus}, 32'd0);
    else     check(sawBus, "R4 access issued", {31'd0, sawBus}, 32'd1);
    @(negedge clk);
    check(rspValid == 1'b0, "R1 response single pulse", {31'd0, rspValid}, 32'd0);
    check(winEnable == modelEnable, "R10 enable model", {31'd0, winEnable},
          {31'd0, modelEnable});
  endtask

  initial begin
    int seedDummy;
    seedDummy = $urandom(32'h5EED);
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    check(reqReady == 1'b1, "R12 ready after reset", {31'd0, reqReady}, 32'd1);
    check(rspValid == 1'b0, "R12 no response after reset", {31'd0, rspValid}, 32'd0);
    check(busReq == 1'b0, "R12 no bus after reset", {31'd0, busReq}, 32'd0);
    check(winEnable == 1'b0, "R10 enable low after reset", {31'd0, winEnable}, 32'd0);

    // directed corners
    runReq(8'd0, 5'd2, 3'd0, 12'h010, 1'b1, 32'hDEAD_BEEF, 0, 0, 32'h0);   // R7, R10 stays low
    runReq(8'd1, 5'd1, 3'd0, 12'h000, 1'b0, 32'h0, 0, 0, 32'h0);           // R6
    runReq(8'd0, 5'd1, 3'd2, 12'hFFF, 1'b0, 32'h0, 0, 2, 32'h1234_5678);   // R3 R5
    runReq(8'd3, 5'd31, 3'd7, 12'h107, 1'b0, 32'h0, 0, 0, 32'hCAFE_0001);  // R4 R2 type 5
    runReq(8'd0, 5'd0, 3'd0, 12'h004, 1'b0, 32'h0, 0, 1, 32'h0BAD_F00D);   // R3 target kept
    runReq(8'd1, 5'd0, 3'd5, 12'h0A2, 1'b1, 32'h5555_AAAA, 0, 3, 32'h0);   // R2 type 4, R9 write
    runReq(8'd2, 5'd9, 3'd1, 12'h040, 1'b0, 32'h0, 1, 4, 32'h1111_1111);   // R8 abort read
    runReq(8'd9, 5'd3, 3'd0, 12'h044, 1'b1, 32'h7777_0000, 1, 0, 32'h0);   // R8 abort write
    runReq(8'd5, 5'd4, 3'd3, 12'h048, 1'b0, 32'h0, 2, 1, 32'h2222_2222);   // R8 abort wins

    // random mix
    for (int n = 0; n < 80; n++) begin
      logic [7:0] b;
      int sel = $urandom_range(0, 3);
      b = (sel == 3) ? 8'($urandom_range(0, 255)) : 8'(sel);
      runReq(b, 5'($urandom_range(0, 3) == 0 ? $urandom_range(0, 31) : $urandom_range(0, 2)),
             3'($urandom_range(0, 7)), 12'($urandom_range(0, 4095)),
             1'($urandom_range(0, 1)), $urandom,
             ($urandom_range(0, 5) == 0) ? 1 : 0, $urandom_range(0, 4), $urandom);
    end

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule